// File: doc/BRIEF.md
# Low-Memory Presence Snooper

This block serves memory reads and writes below the 640 KB boundary (addresses under 0xA0000) of an 8-bit ISA-style bus. It holds an internal copy of that space. It must not contend with a motherboard RAM that may already be fitted. For this reason it learns, one 64 KB page at a time, whether some other device answers reads. The address bits [19:16] select the page.

The first read of a page is a probe. The block stretches the cycle with wait states and keeps its own data drivers off. When the wait ends it compares the byte on the bus with its internal copy:

- If the two are equal, another memory is present. The block stays silent on that page from then on.
- If they differ, the block drives its own byte for the rest of that cycle and answers every later read of the page without waiting.

Every write into the range is stored internally whatever the page has learned. The byte is captured at the end of the write strobe. The wait length is a number of clock cycles computed from the clock frequency and a nanosecond target, which defaults to 800 ns. The internal store keeps the page bits and `OFF_W` low offset bits of the address. The full 64 KB per page needs `OFF_W = 16`.

Top module: `convmem_snooper`

## Requirements
- R1: After reset every page is in the unknown state (code 0), and `bus_doe` and `bus_wait` are low while no strobe is active.
- R2: A read at or above 0xA0000 never raises `bus_wait` or `bus_doe`.
- R3: A read of a page in the unknown state holds `bus_wait` high for exactly WAIT_CYC clock cycles, counting the cycle in which the strobe is first seen. `bus_doe` stays low throughout. WAIT_CYC is 40 at 50 MHz and 800 ns.
- R4: If the bus byte equals the stored byte at the end of the wait, the page becomes foreign (code 1) and `bus_doe` stays low for the rest of that read.
- R5: If the bus byte differs, the page becomes owned (code 2). `bus_doe` rises in the first cycle after `bus_wait` falls and stays high until the strobe drops. `bus_dout` carries the stored byte.
- R6: A read of an owned page raises `bus_doe` in the same cycle as the strobe, with `bus_dout` equal to the stored byte and no wait.
- R7: A read of a foreign page adds no wait and never raises `bus_doe`.
- R8: A write below 0xA0000 is stored whatever the page state. The byte present in the last cycle of `bus_wr` is committed at the first clock edge that sees the strobe low.
- R9: Learning one page leaves every other page's state unchanged.
- R10: `bus_doe` is never high while `bus_rd` is low, and never high together with `bus_wait`.
- R11: A read dropped before its wait ends leaves the page unknown, so the next read probes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 20 | Bus memory address |
| bus_rd | input | 1 | Memory read strobe, active high |
| bus_wr | input | 1 | Memory write strobe, active high |
| bus_din | input | 8 | Byte currently present on the bus data lines |
| bus_dout | output | 8 | Byte the block drives when enabled |
| bus_doe | output | 1 | Data driver enable |
| bus_wait | output | 1 | Wait request (ready held low) |

## Verification
The hardest situation to reach is a read that ends before its probe finishes. The bus never produces it on its own, because the master is held by the wait. The stimulus drops the strobe a few cycles into the wait on one page. It later reads that page again and expects a full-length probe.

Each page is then probed once, and the bus byte is chosen so that the pages alternate between foreign and owned. Every probe still runs the full WAIT_CYC, which shows that deciding earlier pages left the later ones untouched. Repeat reads confirm the learned behaviour, and rewrites confirm that stored data follows writes.

// File: rtl/convsnoop_pkg.sv
package convsnoop_pkg;

    localparam int PAGE_W = 4;

    typedef enum logic [1:0] {
        PG_UNKNOWN = 2'd0,
        PG_FOREIGN = 2'd1,
        PG_OWN     = 2'd2
    } page_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PROBE,
        PH_SERVE,
        PH_QUIET
    } phase_e;

    typedef struct packed {
        logic              valid;
        logic [PAGE_W-1:0] idx;
        page_state_e       next;
    } page_upd_t;

    // clock cycles covering a delay given in ns, rounded up
    function automatic int unsigned wait_cycles(input int unsigned clk_khz,
                                                input int unsigned delay_ns);
        return (clk_khz * delay_ns + 999999) / 1000000;
    endfunction

endpackage

// File: rtl/snoop_page_table.sv
module snoop_page_table
    import convsnoop_pkg::*;
#(
    parameter int NUM_PAGES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PAGE_W-1:0] look_idx,
    input  page_upd_t         upd,
    output page_state_e       look_state
);

    page_state_e ent [NUM_PAGES];

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
        always_ff @(posedge clk) begin
            if (rst)
                ent[g] <= PG_UNKNOWN;
            else if (upd.valid && upd.idx == PAGE_W'(g))
                ent[g] <= upd.next;
        end

        // R9: once learned, a page never falls back to unknown
        decided_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            (ent[g] != PG_UNKNOWN) |=> (ent[g] != PG_UNKNOWN));
    end

    assign look_state = ent[look_idx];

endmodule

// File: rtl/snoop_store.sv
module snoop_store
    import convsnoop_pkg::*;
#(
    parameter int          ADDR_W = 20,
    parameter int          DATA_W = 8,
    parameter int          OFF_W  = 6,
    parameter logic [19:0] LIMIT  = 20'hA0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int IDX_W = PAGE_W + OFF_W;
    localparam int DEPTH = 2 ** IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              wr_q;
    logic              cap_ok;
    logic [IDX_W-1:0]  cap_idx;
    logic [DATA_W-1:0] cap_data;
    logic              commit;

    function automatic logic [IDX_W-1:0] to_idx(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1 -: PAGE_W], a[OFF_W-1:0]};
    endfunction

    // hold the latest address and byte while the strobe is active
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q     <= 1'b0;
            cap_ok   <= 1'b0;
            cap_idx  <= '0;
            cap_data <= '0;
        end else begin
            wr_q <= wr;
            if (wr) begin
                cap_ok   <= (waddr < ADDR_W'(LIMIT));
                cap_idx  <= to_idx(waddr);
                cap_data <= wdata;
            end
        end
    end

    assign commit = wr_q && !wr && cap_ok;

    always_ff @(posedge clk) begin
        if (commit)
            mem[cap_idx] <= cap_data;
    end

    assign rdata = mem[to_idx(raddr)];

endmodule

// File: rtl/snoop_probe_fsm.sv
module snoop_probe_fsm
    import convsnoop_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int WAIT_CYC = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic              hit,
    input  logic [PAGE_W-1:0] page,
    input  page_state_e       pst,
    input  logic [DATA_W-1:0] bus_byte,
    input  logic [DATA_W-1:0] own_byte,
    output logic              doe,
    output logic              wt,
    output page_upd_t         upd
);

    localparam int CNT_W = $clog2(WAIT_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYC - 2);

    phase_e           ph, ph_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             same;

    assign same = (bus_byte == own_byte);

    always_comb begin
        ph_nxt  = ph;
        cnt_nxt = cnt;
        upd     = '0;
        doe     = 1'b0;
        wt      = 1'b0;
        case (ph)
            PH_IDLE: begin
                if (rd && hit) begin
                    case (pst)
                        PG_OWN: begin
                            doe    = 1'b1;
                            ph_nxt = PH_SERVE;
                        end
                        PG_FOREIGN: ph_nxt = PH_QUIET;
                        default: begin
                            wt      = 1'b1;
                            cnt_nxt = '0;
                            ph_nxt  = PH_PROBE;
                        end
                    endcase
                end
            end
            PH_PROBE: begin
                if (!rd) begin
                    ph_nxt = PH_IDLE;
                end else begin
                    wt = 1'b1;
                    if (cnt == LAST) begin
                        upd.valid = 1'b1;
                        upd.idx   = page;
                        upd.next  = same ? PG_FOREIGN : PG_OWN;
                        ph_nxt    = same ? PH_QUIET : PH_SERVE;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
            end
            PH_SERVE: begin
                if (rd) doe = 1'b1;
                else    ph_nxt = PH_IDLE;
            end
            default: begin
                if (!rd) ph_nxt = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else begin
            ph  <= ph_nxt;
            cnt <= cnt_nxt;
        end
    end

    // consecutive wait cycles seen so far, for the length check
    logic [CNT_W:0] run;
    always_ff @(posedge clk) begin
        if (rst)     run <= '0;
        else if (wt) run <= run + 1'b1;
        else         run <= '0;
    end

    // R3
    wait_len_chk: assert property (@(posedge clk) disable iff (rst)
        wt |-> (run < (CNT_W+1)'(WAIT_CYC)));

    // R10
    doe_wait_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(doe && wt));

    // R10
    doe_needs_rd_chk: assert property (@(posedge clk) disable iff (rst)
        doe |-> rd);

    // R2
    range_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_IDLE && !hit) |-> (!doe && !wt));

    // R4
    quiet_after_match_chk: assert property (@(posedge clk) disable iff (rst)
        (upd.valid && upd.next == PG_FOREIGN) |=> !doe);

endmodule

// File: rtl/convmem_snooper.sv
module convmem_snooper
    import convsnoop_pkg::*;
#(
    parameter int          ADDR_W  = 20,
    parameter int          DATA_W  = 8,
    parameter int          OFF_W   = 6,
    parameter logic [19:0] LIMIT   = 20'hA0000,
    parameter int          CLK_KHZ = 50000,
    parameter int          WAIT_NS = 800
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic              bus_wait
);

    localparam int WAIT_CYC  = wait_cycles(CLK_KHZ, WAIT_NS);
    localparam int NUM_PAGES = 2 ** PAGE_W;

    logic [PAGE_W-1:0] page;
    logic              in_range;
    page_state_e       pst;
    page_upd_t         upd;
    logic [DATA_W-1:0] stored;

    assign page     = bus_addr[ADDR_W-1 -: PAGE_W];
    assign in_range = (bus_addr < ADDR_W'(LIMIT));

    snoop_page_table #(.NUM_PAGES(NUM_PAGES)) u_table (
        .clk        (clk),
        .rst        (rst),
        .look_idx   (page),
        .upd        (upd),
        .look_state (pst)
    );

    snoop_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .OFF_W  (OFF_W),
        .LIMIT  (LIMIT)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .waddr (bus_addr),
        .wdata (bus_din),
        .raddr (bus_addr),
        .rdata (stored)
    );

    snoop_probe_fsm #(
        .DATA_W   (DATA_W),
        .WAIT_CYC (WAIT_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .rd       (bus_rd),
        .hit      (in_range),
        .page     (page),
        .pst      (pst),
        .bus_byte (bus_din),
        .own_byte (stored),
        .doe      (bus_doe),
        .wt       (bus_wait),
        .upd      (upd)
    );

    assign bus_dout = stored;

    // R7
    foreign_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (in_range && pst == PG_FOREIGN) |-> !bus_doe);

endmodule

// File: tb/test_convmem_snooper.sv
module test_convmem_snooper;

    localparam int WAIT_CYC = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_din = '0;
    logic [7:0]  bus_dout;
    logic        bus_doe;
    logic        bus_wait;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    convmem_snooper i_convmem_snooper (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_din  (bus_din),
        .bus_dout (bus_dout),
        .bus_doe  (bus_doe),
        .bus_wait (bus_wait)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int p, input int gen);
        return 8'h3C ^ 8'(p * 17) ^ 8'(gen * 8'h5A);
    endfunction

    function automatic logic [19:0] adr(input int p);
        return {4'(p), 16'h0025};
    endfunction

    task automatic do_write(input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_din = d; bus_wr = 1'b1;
        repeat (2) @(negedge clk);
        bus_wr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic probe(input int p, input logic [7:0] d, input bit own, input logic [7:0] exp);
        int n = 0;
        int doe_seen = 0;
        @(negedge clk);
        bus_addr = adr(p); bus_din = d; bus_rd = 1'b1;
        #1;
        while (bus_wait && n < 200) begin
            n++;
            if (bus_doe) doe_seen++;
            @(negedge clk); #1;
        end
        // R3 R9: full wait on every unknown page, drivers off meanwhile
        chk(n == WAIT_CYC, "R3/R9 wait length", n, WAIT_CYC);
        chk(doe_seen == 0, "R3 doe during wait", doe_seen, 0);
        // R4 R5: outcome right after the wait
        chk(bus_doe == own, own ? "R5 doe after mismatch" : "R4 quiet after match", bus_doe, own);
        if (own) chk(bus_dout == exp, "R5 data", bus_dout, exp);
        @(negedge clk); #1;
        chk(bus_doe == own && !bus_wait, "R4/R5 rest of cycle", bus_doe, own);
        bus_rd = 1'b0;
        #1;
        chk(!bus_doe, "R10 doe follows strobe", bus_doe, 0);
        @(negedge clk);
    endtask

    task automatic plain_read(input int p, input bit own, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = adr(p); bus_din = 8'hA5; bus_rd = 1'b1;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk(!bus_wait, own ? "R6 no wait" : "R7 no wait", bus_wait, 0);
            chk(bus_doe == own, own ? "R6 doe at once" : "R7 silent", bus_doe, own);
            if (own) chk(bus_dout == exp, "R6/R8 data", bus_dout, exp);
            @(negedge clk);
        end
        bus_rd = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R1: quiet after reset
        chk(!bus_doe && !bus_wait, "R1 reset outputs", {bus_doe, bus_wait}, 0);

        // R8: fill each page below the limit
        for (int p = 0; p < 10; p++) do_write(adr(p), pat(p, 0));

        // R11: abort a probe early on page 3
        @(negedge clk);
        bus_addr = adr(3); bus_din = pat(3, 0); bus_rd = 1'b1;
        repeat (5) @(negedge clk);
        #1;
        chk(bus_wait, "R11 waiting before abort", bus_wait, 1);
        bus_rd = 1'b0;
        repeat (2) @(negedge clk);

        // R1 R4 R5 R9 R11: probe every page, even pages find another RAM
        for (int p = 0; p < 10; p++) begin
            if (p % 2 == 0) probe(p, pat(p, 0), 1'b0, pat(p, 0));
            else            probe(p, ~pat(p, 0), 1'b1, pat(p, 0));
        end

        // R6 R7: learned behaviour on repeat reads
        for (int p = 0; p < 10; p++) plain_read(p, p % 2 == 1, pat(p, 0));

        // R2: upper pages never answer
        for (int p = 10; p < 16; p++) begin
            @(negedge clk);
            bus_addr = {4'(p), 16'h0100}; bus_rd = 1'b1;
            for (int k = 0; k < 3; k++) begin
                #1;
                chk(!bus_doe && !bus_wait, "R2 above limit", {bus_doe, bus_wait}, 0);
                @(negedge clk);
            end
            bus_rd = 1'b0;
        end

        // R8: rewrite every page whatever its state, read back owned ones
        for (int p = 0; p < 10; p++) do_write(adr(p), pat(p, 1));
        for (int p = 0; p < 10; p++) plain_read(p, p % 2 == 1, pat(p, 1));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule